// File: doc/BRIEF.md
# Power Mode and Clock Source Controller

This block decides which of three clock sources drives the core and the peripherals, and whether each of them is clocked at all. The three sources are a primary oscillator, a low-power secondary oscillator and an internal RC oscillator. Each source reports a "running" flag. Real clock multiplexing is modelled as registered enables in one reference clock domain. The outputs are a one-hot source indicator, a CPU clock enable, a peripheral clock enable and a 3-bit operating-mode code.

Software writes a small control register. It holds an idle-enable bit and a 2-bit source-select field. Writing the select field moves the device among the three Run modes. A one-cycle sleep strobe is the only way into the low-power states. The idle bit held at the moment of the strobe picks between Sleep and the Idle mode of the active source. A wake event returns the block to Run on the active source.

Top module: `pwr_clk_ctrl`

## Requirements
- R1: After reset the block is in primary Run: mode 1, both enables 1, source indicator 3'b001, pending 0, select field 00, idle bit 0.
- R2: The select field maps 00 to the primary source (indicator bit 0), 01 to the secondary source (bit 1), and 10 or 11 to the internal RC source (bit 2). The mode code is 0 for Sleep, 1/2/3 for Run on primary/secondary/RC, and 4/5/6 for Idle on primary/secondary/RC.
- R3: A register write whose requested source is running changes the active source on the same clock edge as the write. The pending flag is 0 afterwards.
- R4: If the requested source is not running, the previous source stays active and the pending flag reads 1. The switch completes on the first edge at which the requested source's running flag is 1, and pending then returns to 0.
- R5: A sleep strobe in Run while the held idle bit is 1 enters the Idle mode of the active source. In that mode the CPU enable is 0, the peripheral enable is 1 and the source indicator is unchanged.
- R6: A sleep strobe in Run while the held idle bit is 0 enters Sleep. In Sleep both enables are 0 and the source indicator is 3'b000.
- R7: In Run, the idle bit has no effect on the outputs, and a wake event has no effect. Only the sleep strobe leaves Run.
- R8: A wake event in Idle or Sleep returns to the Run mode of the active source. The CPU enable is 1 after the next clock edge.
- R9: A sleep strobe while already in Idle or Sleep is ignored.
- R10: Register writes are accepted in Idle and Sleep. The active source switches under the same rule as R3/R4, and the outputs reflect the new source while in Idle and after wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_run_i | input | 3 | Running flags: bit0 primary, bit1 secondary, bit2 RC |
| cfg_we_i | input | 1 | Control register write strobe |
| cfg_idle_i | input | 1 | Idle-enable bit written on cfg_we_i |
| cfg_sel_i | input | 2 | Source-select field written on cfg_we_i |
| sleep_i | input | 1 | One-cycle sleep strobe |
| wake_i | input | 1 | Wake event |
| src_sel_o | output | 3 | One-hot source in use, zero in Sleep |
| cpu_en_o | output | 1 | CPU clock enable |
| per_en_o | output | 1 | Peripheral clock enable |
| mode_o | output | 3 | Operating-mode code |
| pending_o | output | 1 | Requested source not yet running |

## Verification
The bench sweeps every pair of old and new select values against all eight running-flag patterns. This catches a design that switches to a stopped oscillator, which would show a source indicator the bench does not expect and a pending flag of 0. The sweep also catches a design that never finishes a deferred switch. Each pattern is then driven through sleep with both idle values. This exposes a design that reads the idle bit live in Run, or that takes a second strobe in Idle as a move to Sleep. Writes made while in a low-power state, followed by a wake, show whether the design returns to a stale source or delays the CPU enable.

// File: rtl/pwr_clk_pkg.sv
package pwr_clk_pkg;

    localparam int NUM_SRC = 3;
    localparam int SEL_W   = 2;
    localparam int MODE_W  = 3;
    localparam int IDX_W   = $clog2(NUM_SRC);

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_IDLE  = 2'd1,
        ST_SLEEP = 2'd2
    } pwr_state_e;

    localparam logic [MODE_W-1:0] MODE_SLEEP     = 3'd0;
    localparam logic [MODE_W-1:0] MODE_RUN_BASE  = 3'd1;
    localparam logic [MODE_W-1:0] MODE_IDLE_BASE = 3'd4;

    typedef struct packed {
        logic             idle;
        logic [SEL_W-1:0] sel;
    } cfg_t;

    typedef struct packed {
        logic [NUM_SRC-1:0] act;
        logic               pend;
    } sw_t;

endpackage

// File: rtl/pwr_cfg_reg.sv
module pwr_cfg_reg
    import pwr_clk_pkg::*;
#(
    parameter int N_SRC = NUM_SRC,
    parameter int S_W   = SEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic             idle_i,
    input  logic [S_W-1:0]   sel_i,
    output logic             idle_q_o,
    output logic [N_SRC-1:0] req_oh_o
);
    localparam int LAST = N_SRC - 1;

    cfg_t cfg_d, cfg_q;
    logic [S_W-1:0] req_sel;

    always_comb begin
        cfg_d = cfg_q;
        if (we_i) begin
            cfg_d.idle = idle_i;
            cfg_d.sel  = sel_i;
        end
        req_sel = we_i ? sel_i : cfg_q.sel;
    end

    generate
        for (genvar g = 0; g < N_SRC; g++) begin : g_dec
            if (g == LAST) begin : g_top
                assign req_oh_o[g] = (int'(req_sel) >= LAST);
            end else begin : g_low
                assign req_oh_o[g] = (int'(req_sel) == g);
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign idle_q_o = cfg_q.idle;

    assert_req_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(req_oh_o) == 1);

endmodule

// File: rtl/pwr_src_switch.sv
module pwr_src_switch
    import pwr_clk_pkg::*;
#(
    parameter int N_SRC = NUM_SRC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] req_oh_i,
    input  logic [N_SRC-1:0] src_run_i,
    output logic [N_SRC-1:0] act_oh_o,
    output logic             pending_o
);
    sw_t sw_d, sw_q;
    logic req_ok;

    always_comb begin
        sw_d   = sw_q;
        req_ok = |(req_oh_i & src_run_i);
        if ((req_oh_i != sw_q.act) && req_ok) begin
            sw_d.act = req_oh_i;
        end
        sw_d.pend = (req_oh_i != sw_d.act);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sw_q.act  <= {{(N_SRC-1){1'b0}}, 1'b1};
            sw_q.pend <= 1'b0;
        end else begin
            sw_q <= sw_d;
        end
    end

    assign act_oh_o  = sw_q.act;
    assign pending_o = sw_q.pend;

    assert_act_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(act_oh_o) == 1);

    // R3/R4: a source only becomes active if it was reported running
    assert_switch_to_running_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (act_oh_o != $past(act_oh_o)) |-> (|($past(src_run_i) & act_oh_o)));

    assert_pending_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_o && !(|(req_oh_i & src_run_i))) |=> $stable(act_oh_o));

endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
    import pwr_clk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sleep_i,
    input  logic       wake_i,
    input  logic       idle_i,
    output pwr_state_e state_o
);
    pwr_state_e state_d, state_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (sleep_i) state_d = idle_i ? ST_IDLE : ST_SLEEP;
            end
            ST_IDLE, ST_SLEEP: begin
                if (wake_i) state_d = ST_RUN;
            end
            default: state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    assign state_o = state_q;

    assert_run_needs_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !sleep_i) |=> state_q == ST_RUN);

    assert_idle_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && sleep_i && idle_i) |=> state_q == ST_IDLE);

    assert_sleep_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && sleep_i && !idle_i) |=> state_q == ST_SLEEP);

    assert_wake_return_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_RUN && wake_i) |=> state_q == ST_RUN);

    assert_strobe_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_RUN && !wake_i) |=> $stable(state_q));

endmodule

// File: rtl/pwr_clk_ctrl.sv
module pwr_clk_ctrl
    import pwr_clk_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_SRC-1:0]  src_run_i,
    input  logic                cfg_we_i,
    input  logic                cfg_idle_i,
    input  logic [SEL_W-1:0]    cfg_sel_i,
    input  logic                sleep_i,
    input  logic                wake_i,
    output logic [NUM_SRC-1:0]  src_sel_o,
    output logic                cpu_en_o,
    output logic                per_en_o,
    output logic [MODE_W-1:0]   mode_o,
    output logic                pending_o
);
    logic               idle_q;
    logic [NUM_SRC-1:0] req_oh;
    logic [NUM_SRC-1:0] act_oh;
    logic [IDX_W-1:0]   act_idx;
    pwr_state_e         state;

    pwr_cfg_reg #(.N_SRC(NUM_SRC), .S_W(SEL_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_i     (cfg_we_i),
        .idle_i   (cfg_idle_i),
        .sel_i    (cfg_sel_i),
        .idle_q_o (idle_q),
        .req_oh_o (req_oh)
    );

    pwr_src_switch #(.N_SRC(NUM_SRC)) u_sw (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_oh_i  (req_oh),
        .src_run_i (src_run_i),
        .act_oh_o  (act_oh),
        .pending_o (pending_o)
    );

    pwr_mode_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .sleep_i (sleep_i),
        .wake_i  (wake_i),
        .idle_i  (idle_q),
        .state_o (state)
    );

    always_comb begin
        act_idx = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (act_oh[i]) act_idx = IDX_W'(i);
        end
    end

    always_comb begin
        cpu_en_o  = (state == ST_RUN);
        per_en_o  = (state != ST_SLEEP);
        src_sel_o = (state == ST_SLEEP) ? '0 : act_oh;
        unique case (state)
            ST_RUN:   mode_o = MODE_RUN_BASE  + MODE_W'(act_idx);
            ST_IDLE:  mode_o = MODE_IDLE_BASE + MODE_W'(act_idx);
            default:  mode_o = MODE_SLEEP;
        endcase
    end

    assert_src_onehot0_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(src_sel_o));

    assert_sleep_gates_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MODE_SLEEP) |-> (!cpu_en_o && !per_en_o && src_sel_o == '0));

    assert_idle_gates_cpu_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o >= MODE_IDLE_BASE) |-> (!cpu_en_o && per_en_o));

    assert_run_clocks_both_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_en_o |-> (per_en_o && src_sel_o != '0));

endmodule

// File: tb/pwr_clk_ctrl_bench.sv
`timescale 1ns/1ps
module pwr_clk_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] src_run_i = 3'b111;
    logic       cfg_we_i = 1'b0;
    logic       cfg_idle_i = 1'b0;
    logic [1:0] cfg_sel_i = 2'b00;
    logic       sleep_i = 1'b0;
    logic       wake_i = 1'b0;
    logic [2:0] src_sel_o;
    logic       cpu_en_o, per_en_o, pending_o;
    logic [2:0] mode_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    int m_sel, m_act, m_state;
    bit m_idle, m_pend;

    always #2.5 clk = ~clk;

    pwr_clk_ctrl u_pwr_clk_ctrl (
        .clk(clk), .rst_n(rst_n), .src_run_i(src_run_i),
        .cfg_we_i(cfg_we_i), .cfg_idle_i(cfg_idle_i), .cfg_sel_i(cfg_sel_i),
        .sleep_i(sleep_i), .wake_i(wake_i), .src_sel_o(src_sel_o),
        .cpu_en_o(cpu_en_o), .per_en_o(per_en_o), .mode_o(mode_o),
        .pending_o(pending_o)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        int e_src, e_mode;
        e_src  = (m_state == 2) ? 0 : (1 << m_act);
        e_mode = (m_state == 2) ? 0 : ((m_state == 0) ? 1 + m_act : 4 + m_act);
        chk(tag, "src_sel", int'(src_sel_o), e_src);
        chk(tag, "cpu_en",  int'(cpu_en_o),  (m_state == 0) ? 1 : 0);
        chk(tag, "per_en",  int'(per_en_o),  (m_state != 2) ? 1 : 0);
        chk(tag, "mode",    int'(mode_o),    e_mode);
        chk(tag, "pending", int'(pending_o), int'(m_pend));
    endtask

    task automatic step(input bit we, input bit idl, input int sel, input bit slp,
                        input bit wk, input logic [2:0] run, input string tag);
        int  req;
        bit  old_idle;
        cfg_we_i   = we;
        cfg_idle_i = idl;
        cfg_sel_i  = sel[1:0];
        sleep_i    = slp;
        wake_i     = wk;
        src_run_i  = run;
        req      = we ? ((sel >= 2) ? 2 : sel) : m_sel;
        old_idle = m_idle;
        if (we) begin
            m_sel  = req;
            m_idle = idl;
        end
        if (req != m_act && run[req]) m_act = req;
        m_pend = (req != m_act);
        if (m_state == 0) begin
            if (slp) m_state = old_idle ? 1 : 2;
        end else if (wk) begin
            m_state = 0;
        end
        @(posedge clk);
        @(negedge clk);
        check_all(tag);
    endtask

    initial begin
        m_sel = 0; m_act = 0; m_state = 0; m_idle = 0; m_pend = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1");
        // R1: idle bit cleared at reset, so a strobe yields Sleep
        step(0, 0, 0, 1, 0, 3'b111, "R1");
        step(0, 0, 0, 0, 1, 3'b111, "R1");

        for (int s = 0; s < 4; s++) begin
            for (int t = 0; t < 4; t++) begin
                for (int m = 0; m < 8; m++) begin
                    int ti;
                    ti = (t >= 2) ? 2 : t;
                    step(1, 0, s, 0, 0, 3'b111, "R2");
                    step(1, 0, t, 0, 0, m[2:0], m[ti] ? "R3" : "R4");
                    step(0, 0, 0, 0, 0, 3'b111, "R4");
                    step(1, m[0], t, 0, 0, 3'b111, "R7");
                    step(0, 0, 0, 1, 0, 3'b111, m[0] ? "R5" : "R6");
                    step(0, 0, 0, 1, 0, 3'b111, "R9");
                    step(1, 0, s, 0, 0, m[2:0], "R10");
                    step(0, 0, 0, 0, 1, 3'b111, "R8");
                    step(0, 0, 0, 0, 1, 3'b111, "R7");
                end
            end
        end

        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #(100000 * 5);
        if (!done) begin
            done = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule